// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands and returns a 32-bit product. A front end classifies each operand as zero, normal, infinity or NaN, and settles the special cases before the arithmetic path is consulted. Those cases are a NaN operand, zero times infinity, an infinity operand and a zero operand. For ordinary operands, the biased exponents are summed and re-biased. The two 24-bit significands, with their hidden leading one, are multiplied into a 48-bit product. The last phase normalizes that product, rounds it to nearest with ties to even, and saturates or flushes values that fall out of range.

The block is a two-stage pipeline with one operation accepted per cycle. An operand pair presented with `in_valid` high produces `out_valid`, `result` and `invalid` two rising edges later. Denormal encodings are not produced, and on input they are read as zero. Only the invalid condition is flagged. A parameter chooses how the significand product is formed: a behavioural multiply, or an unrolled sum of shifted partial products.

Top module: `fp32_mul`

## Requirements
- R1: Every result that is not NaN, including zero and infinity results, carries sign bit 31 equal to the XOR of the operands' sign bits.
- R2: For two normal operands, the biased result exponent is ea + eb - 127. It is incremented by one when bit 47 of the 48-bit significand product is set, and the product is then taken one place further right.
- R3: The 23 stored fraction bits are rounded to nearest, ties to even. The result rounds up when the first dropped bit is 1 and either any later dropped bit is 1 or the kept least significant bit is 1.
- R4: If rounding carries out of the 24-bit significand, the significand becomes 1.0 and the exponent increases by one.
- R5: A final biased exponent of 255 or more gives infinity (exponent field all ones, fraction zero). An exponent of exactly 254 is kept.
- R6: A final biased exponent of 0 or below gives a zero of the result's sign. No result has exponent field 0 with a nonzero fraction.
- R7: An operand whose exponent field is 0, whatever its fraction, counts as zero. Zero times a finite value gives a signed zero.
- R8: Infinity times a nonzero finite value or times infinity gives an infinity of the XOR sign.
- R9: Zero times infinity, in either order and with any signs, gives 0x7FC00000 with `invalid` set. `invalid` is high only in such a cycle.
- R10: A NaN operand (exponent field all ones, fraction nonzero) gives 0x7FC00000 with `invalid` clear, even when the other operand is zero or infinity.
- R11: `out_valid` is high exactly two rising edges after a cycle with `in_valid` high. Back-to-back inputs give back-to-back outputs. Synchronous reset clears `out_valid`, `result` and `invalid` to zero and drops any operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair on `op_a`/`op_b` is valid this cycle |
| op_a | input | 32 | First operand, single-precision encoding |
| op_b | input | 32 | Second operand, single-precision encoding |
| out_valid | output | 1 | `result` and `invalid` hold a new product |
| result | output | 32 | Product, single-precision encoding |
| invalid | output | 1 | Zero-times-infinity operation |

## Verification
Some checks run on every cycle, using the operand pair delayed to line up with the output. They cover the two-cycle valid latency, the sign rule, the absence of denormal outputs, and the NaN, zero-times-infinity, infinity and zero outcomes. These follow from classifying the operands alone. Exponent arithmetic, tie handling in rounding, the rounding carry, and the exact saturation and flush boundaries depend on the significand values. Only the bench's vectors with precomputed products show those, run through both multiplier variants, together with its directed reset and back-to-back sequences.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP = (1 << EXP_W) - 1;
    localparam int XE_W    = EXP_W + 3;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } opcls_e;

    typedef enum logic [1:0] {
        RES_CALC,
        RES_ZERO,
        RES_INF,
        RES_NAN
    } reskind_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fpword_t;

    typedef struct packed {
        logic              valid;
        reskind_e          kind;
        logic              sign;
        logic              invalid;
        logic [XE_W-1:0]   exp_sum;
        logic [PROD_W-1:0] prod;
    } mid_t;

    function automatic fpword_t make_qnan();
        fpword_t w;
        w.sign = 1'b0;
        w.exp  = '1;
        w.frac = '0;
        w.frac[FRAC_W-1] = 1'b1;
        return w;
    endfunction

    function automatic fpword_t make_inf(input logic s);
        fpword_t w;
        w.sign = s;
        w.exp  = '1;
        w.frac = '0;
        return w;
    endfunction

    function automatic fpword_t make_zero(input logic s);
        fpword_t w;
        w.sign = s;
        w.exp  = '0;
        w.frac = '0;
        return w;
    endfunction

endpackage

// File: rtl/fpm_classify.sv
module fpm_classify
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output opcls_e            cls,
    output logic              sign,
    output logic [EXP_W-1:0]  exp,
    output logic [SIG_W-1:0]  sig
);
    fpword_t f;
    logic    exp_zero;
    logic    exp_ones;
    logic    frac_nz;

    assign f        = fpword_t'(word);
    assign exp_zero = (f.exp == '0);
    assign exp_ones = (f.exp == '1);
    assign frac_nz  = (f.frac != '0);
    assign sign     = f.sign;
    assign exp      = f.exp;
    assign sig      = {1'b1, f.frac};

    always_comb begin
        if (exp_ones)
            cls = frac_nz ? CLS_NAN : CLS_INF;
        else if (exp_zero)
            cls = CLS_ZERO;
        else
            cls = CLS_NORM;
    end
endmodule

// File: rtl/fpm_front.sv
module fpm_front
    import fpm_pkg::*;
(
    input  opcls_e           cls_a,
    input  opcls_e           cls_b,
    input  logic             sign_a,
    input  logic             sign_b,
    input  logic [EXP_W-1:0] exp_a,
    input  logic [EXP_W-1:0] exp_b,
    output reskind_e         kind,
    output logic             sign,
    output logic             invalid,
    output logic [XE_W-1:0]  exp_sum
);
    localparam int PAD_W = XE_W - EXP_W;

    logic any_nan;
    logic any_inf;
    logic any_zero;
    logic zero_inf;

    assign any_nan  = (cls_a == CLS_NAN)  || (cls_b == CLS_NAN);
    assign any_inf  = (cls_a == CLS_INF)  || (cls_b == CLS_INF);
    assign any_zero = (cls_a == CLS_ZERO) || (cls_b == CLS_ZERO);
    assign zero_inf = any_inf && any_zero;
    assign sign     = sign_a ^ sign_b;

    assign exp_sum = {{PAD_W{1'b0}}, exp_a} + {{PAD_W{1'b0}}, exp_b}
                   - XE_W'(BIAS);

    always_comb begin
        invalid = 1'b0;
        if (any_nan) begin
            kind = RES_NAN;
        end else if (zero_inf) begin
            kind    = RES_NAN;
            invalid = 1'b1;
        end else if (any_inf) begin
            kind = RES_INF;
        end else if (any_zero) begin
            kind = RES_ZERO;
        end else begin
            kind = RES_CALC;
        end
    end
endmodule

// File: rtl/fpm_sigmul.sv
module fpm_sigmul
    import fpm_pkg::*;
#(
    parameter int MUL_STYLE = 0
) (
    input  logic [SIG_W-1:0]  sig_a,
    input  logic [SIG_W-1:0]  sig_b,
    output logic [PROD_W-1:0] prod
);
    generate
        if (MUL_STYLE == 0) begin : g_behav
            assign prod = {{SIG_W{1'b0}}, sig_a} * {{SIG_W{1'b0}}, sig_b};
        end else begin : g_shift_add
            logic [PROD_W-1:0] acc [SIG_W+1];
            assign acc[0] = '0;
            for (genvar i = 0; i < SIG_W; i++) begin : g_row
                logic [PROD_W-1:0] part;
                assign part       = sig_b[i] ? ({{SIG_W{1'b0}}, sig_a} << i) : '0;
                assign acc[i + 1] = acc[i] + part;
            end
            assign prod = acc[SIG_W];
        end
    endgenerate
endmodule

// File: rtl/fpm_round.sv
module fpm_round
    import fpm_pkg::*;
(
    input  logic [PROD_W-1:0] prod,
    input  logic [XE_W-1:0]   exp_sum,
    input  logic              sign,
    output logic [WORD_W-1:0] word
);
    localparam int LOW_W = PROD_W - SIG_W - 1;

    logic              top;
    logic [SIG_W-1:0]  mant;
    logic              guard;
    logic              sticky;
    logic              rnd_up;
    logic [SIG_W:0]    mant_rnd;
    logic              carry;
    logic [FRAC_W-1:0] frac;
    logic [XE_W-1:0]   exp_norm;
    logic [XE_W-1:0]   exp_fin;
    logic              exp_neg;
    logic              exp_nil;
    logic              exp_big;
    fpword_t           w;

    assign top      = prod[PROD_W-1];
    assign mant     = top ? prod[PROD_W-1 -: SIG_W] : prod[PROD_W-2 -: SIG_W];
    assign guard    = top ? prod[LOW_W] : prod[LOW_W-1];
    assign sticky   = top ? (|prod[LOW_W-1:0]) : (|prod[LOW_W-2:0]);
    assign rnd_up   = guard && (sticky || mant[0]);
    assign mant_rnd = {1'b0, mant} + {{SIG_W{1'b0}}, rnd_up};
    assign carry    = mant_rnd[SIG_W];
    assign frac     = carry ? mant_rnd[FRAC_W:1] : mant_rnd[FRAC_W-1:0];
    assign exp_norm = exp_sum + {{(XE_W-1){1'b0}}, top};
    assign exp_fin  = exp_norm + {{(XE_W-1){1'b0}}, carry};
    assign exp_neg  = exp_fin[XE_W-1];
    assign exp_nil  = (exp_fin == '0);
    assign exp_big  = !exp_neg && (exp_fin >= XE_W'(EXP_TOP));

    always_comb begin
        if (exp_big) begin
            w = make_inf(sign);
        end else if (exp_neg || exp_nil) begin
            w = make_zero(sign);
        end else begin
            w.sign = sign;
            w.exp  = exp_fin[EXP_W-1:0];
            w.frac = frac;
        end
    end

    assign word = WORD_W'(w);
endmodule

// File: rtl/fp32_mul.sv
module fp32_mul
    import fpm_pkg::*;
#(
    parameter int MUL_STYLE = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   op_a,
    input  logic [WORD_W-1:0]   op_b,
    output logic                out_valid,
    output logic [WORD_W-1:0]   result,
    output logic                invalid
);
    localparam int NOPS = 2;

    logic [WORD_W-1:0] ops     [NOPS];
    opcls_e            cls     [NOPS];
    logic              sgn     [NOPS];
    logic [EXP_W-1:0]  exps    [NOPS];
    logic [SIG_W-1:0]  sigs    [NOPS];

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    generate
        for (genvar k = 0; k < NOPS; k++) begin : g_cls
            fpm_classify u_cls (
                .word (ops[k]),
                .cls  (cls[k]),
                .sign (sgn[k]),
                .exp  (exps[k]),
                .sig  (sigs[k])
            );
        end
    endgenerate

    reskind_e          kind_c;
    logic              sign_c;
    logic              inv_c;
    logic [XE_W-1:0]   esum_c;
    logic [PROD_W-1:0] prod_c;

    fpm_front u_front (
        .cls_a   (cls[0]),
        .cls_b   (cls[1]),
        .sign_a  (sgn[0]),
        .sign_b  (sgn[1]),
        .exp_a   (exps[0]),
        .exp_b   (exps[1]),
        .kind    (kind_c),
        .sign    (sign_c),
        .invalid (inv_c),
        .exp_sum (esum_c)
    );

    fpm_sigmul #(.MUL_STYLE(MUL_STYLE)) u_mul (
        .sig_a (sigs[0]),
        .sig_b (sigs[1]),
        .prod  (prod_c)
    );

    mid_t s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= in_valid;
            if (in_valid) begin
                s1.kind    <= kind_c;
                s1.sign    <= sign_c;
                s1.invalid <= inv_c;
                s1.exp_sum <= esum_c;
                s1.prod    <= prod_c;
            end
        end
    end

    logic [WORD_W-1:0] rounded;
    logic [WORD_W-1:0] final_w;

    fpm_round u_round (
        .prod    (s1.prod),
        .exp_sum (s1.exp_sum),
        .sign    (s1.sign),
        .word    (rounded)
    );

    always_comb begin
        unique case (s1.kind)
            RES_NAN:  final_w = WORD_W'(make_qnan());
            RES_INF:  final_w = WORD_W'(make_inf(s1.sign));
            RES_ZERO: final_w = WORD_W'(make_zero(s1.sign));
            default:  final_w = rounded;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            invalid   <= 1'b0;
        end else begin
            out_valid <= s1.valid;
            invalid   <= s1.valid && s1.invalid;
            if (s1.valid)
                result <= final_w;
        end
    end
endmodule

// File: rtl/fpm_checker.sv
module fpm_checker
    import fpm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic              invalid
);
    localparam logic [WORD_W-1:0] QNAN = WORD_W'(make_qnan());
    localparam logic [WORD_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    logic              v_d1, v_d2;
    logic [WORD_W-1:0] a_d1, a_d2, b_d1, b_d2;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_d1 <= 1'b0; v_d2 <= 1'b0;
            a_d1 <= '0; a_d2 <= '0; b_d1 <= '0; b_d2 <= '0;
        end else begin
            v_d1 <= in_valid; v_d2 <= v_d1;
            a_d1 <= op_a;     a_d2 <= a_d1;
            b_d1 <= op_b;     b_d2 <= b_d1;
        end
    end

    function automatic logic is_nan(input logic [WORD_W-1:0] x);
        return (x[WORD_W-2 -: EXP_W] == '1) && (x[FRAC_W-1:0] != '0);
    endfunction
    function automatic logic is_inf(input logic [WORD_W-1:0] x);
        return (x[WORD_W-2 -: EXP_W] == '1) && (x[FRAC_W-1:0] == '0);
    endfunction
    function automatic logic is_zero(input logic [WORD_W-1:0] x);
        return (x[WORD_W-2 -: EXP_W] == '0);
    endfunction

    logic nan_in, inf_in, zero_in, zinf_in;
    assign nan_in  = is_nan(a_d2) || is_nan(b_d2);
    assign inf_in  = is_inf(a_d2) || is_inf(b_d2);
    assign zero_in = is_zero(a_d2) || is_zero(b_d2);
    assign zinf_in = inf_in && zero_in;

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid == v_d2); // R11
    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !nan_in && !zinf_in) |-> (result[WORD_W-1] == (a_d2[WORD_W-1] ^ b_d2[WORD_W-1]))); // R1
    AST_NO_DENORM: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !((result[WORD_W-2 -: EXP_W] == '0) && (result[FRAC_W-1:0] != '0))); // R6
    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (out_valid && zero_in && !inf_in && !nan_in) |-> (result[WORD_W-2:0] == '0)); // R7
    AST_INF_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (out_valid && inf_in && !zero_in && !nan_in) |-> (result[WORD_W-2:0] == INF_MAG)); // R8
    AST_ZERO_TIMES_INF: assert property (@(posedge clk) disable iff (rst)
        (out_valid && zinf_in && !nan_in) |-> (result == QNAN && invalid)); // R9
    AST_INVALID_ONLY: assert property (@(posedge clk) disable iff (rst)
        invalid |-> (out_valid && zinf_in && !nan_in)); // R9
    AST_NAN_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (out_valid && nan_in) |-> (result == QNAN && !invalid)); // R10
endmodule

bind fp32_mul fpm_checker u_fpm_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .result    (result),
    .invalid   (invalid)
);

// File: tb/tb_fp32_mul.sv
`timescale 1ns/1ps
module tb_fp32_mul;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid, invalid, out_valid_alt, invalid_alt;
    logic [31:0] result, result_alt;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    fp32_mul #(.MUL_STYLE(0)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .result(result), .invalid(invalid)
    );

    fp32_mul #(.MUL_STYLE(1)) dut_alt (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid_alt), .result(result_alt), .invalid(invalid_alt)
    );

    // {op_a, op_b, expected result, expected invalid, requirement number}
    localparam int NV = 26;
    localparam logic [100:0] VECS [NV] = '{
        {32'h3F800000, 32'h3F800000, 32'h3F800000, 1'b0, 4'd2},  // R2 1*1
        {32'h40000000, 32'h40400000, 32'h40C00000, 1'b0, 4'd2},  // R2 2*3
        {32'h3FC00000, 32'h3FC00000, 32'h40100000, 1'b0, 4'd2},  // R2 normalize shift
        {32'hBFC00000, 32'h40000000, 32'hC0400000, 1'b0, 4'd1},  // R1 neg*pos
        {32'hBFC00000, 32'hC0000000, 32'h40400000, 1'b0, 4'd1},  // R1 neg*neg
        {32'h3F800800, 32'h3F800800, 32'h3F801000, 1'b0, 4'd3},  // R3 tie, even kept
        {32'h3FC00000, 32'h3FC00002, 32'h40100002, 1'b0, 4'd3},  // R3 tie, odd up
        {32'h3F800001, 32'h3FC00000, 32'h3FC00002, 1'b0, 4'd3},  // R3 tie, odd up
        {32'h3F800001, 32'h3FE00000, 32'h3FE00002, 1'b0, 4'd3},  // R3 above half
        {32'h3FFFFFFE, 32'h3F800001, 32'h40000000, 1'b0, 4'd4},  // R4 carry out
        {32'h7F000000, 32'h40000000, 32'h7F800000, 1'b0, 4'd5},  // R5 overflow
        {32'hFF000000, 32'h40000000, 32'hFF800000, 1'b0, 4'd5},  // R5 neg overflow
        {32'h7F000000, 32'h3F800000, 32'h7F000000, 1'b0, 4'd5},  // R5 exp 254 kept
        {32'h00800000, 32'h3F000000, 32'h00000000, 1'b0, 4'd6},  // R6 flush
        {32'h80800000, 32'h3F000000, 32'h80000000, 1'b0, 4'd6},  // R6 signed flush
        {32'h00800000, 32'h3F800000, 32'h00800000, 1'b0, 4'd6},  // R6 exp 1 kept
        {32'h00000000, 32'h40A00000, 32'h00000000, 1'b0, 4'd7},  // R7 +0
        {32'h80000000, 32'h40A00000, 32'h80000000, 1'b0, 4'd7},  // R7 -0
        {32'h00000001, 32'h40000000, 32'h00000000, 1'b0, 4'd7},  // R7 denormal in
        {32'h7F800000, 32'hC0000000, 32'hFF800000, 1'b0, 4'd8},  // R8 inf*finite
        {32'h7F800000, 32'hFF800000, 32'hFF800000, 1'b0, 4'd8},  // R8 inf*inf
        {32'h00000000, 32'h7F800000, 32'h7FC00000, 1'b1, 4'd9},  // R9 0*inf
        {32'hFF800000, 32'h80000000, 32'h7FC00000, 1'b1, 4'd9},  // R9 -inf*-0
        {32'h7FC12345, 32'h3F800000, 32'h7FC00000, 1'b0, 4'd10}, // R10 qnan
        {32'h00000000, 32'h7F800001, 32'h7FC00000, 1'b0, 4'd10}, // R10 nan*0
        {32'h7F800001, 32'h7F800000, 32'h7FC00000, 1'b0, 4'd10}  // R10 nan*inf
    };

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_a = a;
        op_b = b;
        in_valid = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!out_valid && !invalid && result == 32'h0, "R11 reset state",
              {invalid, out_valid, result[29:0]}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid, "R11 idle no output", {31'b0, out_valid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] va, vb, vr;
            logic        vi;
            logic [3:0]  vq;
            string       tag;
            {va, vb, vr, vi, vq} = VECS[i];
            tag = $sformatf("R%0d vec%0d", vq, i);
            issue(va, vb);
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            check(out_valid && result == vr && invalid == vi, tag,
                  result ^ {invalid, 30'b0, out_valid}, vr ^ {vi, 30'b0, 1'b1});
            check(out_valid_alt && result_alt == vr && invalid_alt == vi,
                  {tag, " shift-add"}, result_alt, vr);
        end

        // R11 single pulse: out_valid drops one cycle later
        @(negedge clk);
        check(!out_valid && !invalid, "R11 pulse ends", {30'b0, invalid, out_valid}, 32'h0);

        // R11 back-to-back, R9 invalid only in its own cycle
        issue(32'h00000000, 32'h7F800000);
        issue(32'h40000000, 32'h40400000);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && invalid && result == 32'h7FC00000, "R9 first of pair",
              result, 32'h7FC00000);
        @(negedge clk);
        check(out_valid && !invalid && result == 32'h40C00000, "R11 second of pair",
              result, 32'h40C00000);
        @(negedge clk);
        check(!out_valid && !invalid, "R11 pair ends", {30'b0, invalid, out_valid}, 32'h0);

        // R11 reset drops an operation in flight
        issue(32'h3F800000, 32'h40000000);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(!out_valid && result == 32'h0, "R11 reset clears", result, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid, "R11 flight dropped", {31'b0, out_valid}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule